// File: doc/BRIEF.md
# I2C SCL Tap-Based Clock Divider

This block produces the serial clock timing for an I2C master. A 6-bit divider value, written by the host, is split into a 3-bit tap index and a 3-bit scale index. The tap index picks a tap count from a fixed table. The scale index picks a pair of delays from a second table: the delay to the first tap and the delay from one tap to the next. The half period in input clock cycles is `first + (tap - 1) * step + 2`, and the full SCL period is twice that.

The byte engine reads three things from the block. `scl_req` is the requested SCL level: low for the first half of each period and high for the second. `tick` is a one-cycle pulse at every quarter boundary. `phase` gives the current quarter, with the start of quarter 1 being the SDA change point and the start of quarter 3 the sample point. When the enable input is low the counter is held at zero and SCL is released. A divider write made while the block is running is held back until the current period has finished, so no SCL period is ever cut short or stretched by a reprogram.

Top module: `scl_tap_divider`

## Requirements
- R1: The tap index is {bit 5, bits 1:0} of the divider value, mapping 0..7 to tap counts 9, 10, 12, 15, 5, 6, 7, 8. The scale index is bits 4:2, mapping 0..7 to (first, step) pairs (4,1), (4,2), (6,4), (6,8), (14,16), (30,32), (62,64), (126,128). The SCL period is 2 × H, where H = first + (tap − 1) × step + 2.
- R2: While enabled, `scl_req` is 0 for the first H cycles of each period and 1 for the next H cycles.
- R3: `tick` pulses at period offsets 0, Q, H and H+Q, where Q = floor(H/2). `phase` is 0 at offset 0 and is 1, 2 and 3 at the ticks at offsets Q, H and H+Q.
- R4: While `en` is 0, `scl_req` is 1, `tick` is 0 and `phase` is 0. The first cycle with `en` high is offset 0 of a new period, with SCL low and a tick.
- R5: A divider write while enabled does not alter the period in progress. It takes effect from the next period boundary.
- R6: A divider write while disabled takes effect at once, so the first period after enabling uses it.
- R7: The extremes are supported: value 0x20 gives a 20-cycle period, and value 0x1F gives a 3840-cycle period.
- R8: After reset the divider value is 0, giving a 28-cycle period, and SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Divider enable; low holds the counter and releases SCL |
| div_we | input | 1 | Divider value write strobe |
| div_wdata | input | DIV_W | Divider value to write |
| scl_req | output | 1 | Requested SCL level (1 = released/high) |
| tick | output | 1 | Quarter-period boundary pulse |
| phase | output | 2 | Current quarter of the SCL period |

## Verification
The assertions assume that `en` and `div_we` change only synchronously with `clk`. They also assume that the divider value only ever changes through a write, so the active value stays constant for the whole of a running period. The stimulus drives every input a short time after the rising edge. It writes while disabled and in the middle of a running period, but never in the wrap cycle. It always measures only periods that ran to completion, since a period cut short by disabling has no defined length.

// File: rtl/scl_tap_divider.sv
module scl_tap_divider #(
  parameter int DIV_W = 6,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             scl_req,
  output logic             tick,
  output logic [1:0]       phase
);

  function automatic logic [4:0] tap_of(input logic [2:0] i);
    case (i)
      3'd0: tap_of = 5'd9;
      3'd1: tap_of = 5'd10;
      3'd2: tap_of = 5'd12;
      3'd3: tap_of = 5'd15;
      3'd4: tap_of = 5'd5;
      3'd5: tap_of = 5'd6;
      3'd6: tap_of = 5'd7;
      default: tap_of = 5'd8;
    endcase
  endfunction

  function automatic logic [7:0] first_of(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: first_of = 8'd4;
      3'd2, 3'd3: first_of = 8'd6;
      3'd4: first_of = 8'd14;
      3'd5: first_of = 8'd30;
      3'd6: first_of = 8'd62;
      default: first_of = 8'd126;
    endcase
  endfunction

  logic [DIV_W-1:0] div_act, div_pend;
  logic             pend_v;
  logic [CNT_W-1:0] cnt, half, qtr, per_last, tap_m1, step;
  logic [2:0]       tap_i, scl_i;
  logic             wrap;

  assign tap_i    = {div_act[5], div_act[1:0]};
  assign scl_i    = div_act[4:2];
  assign tap_m1   = CNT_W'(tap_of(tap_i)) - CNT_W'(1);
  assign step     = CNT_W'(1) << scl_i;
  assign half     = CNT_W'(first_of(scl_i)) + tap_m1 * step + CNT_W'(2);
  assign qtr      = half >> 1;
  assign per_last = (half << 1) - CNT_W'(1);
  assign wrap     = en && (cnt == per_last);

  assign scl_req = !en || (cnt >= half);
  assign tick    = en && (cnt == '0 || cnt == qtr || cnt == half || cnt == half + qtr);
  assign phase   = !en ? 2'd0 :
                   (cnt < qtr)         ? 2'd0 :
                   (cnt < half)        ? 2'd1 :
                   (cnt < half + qtr)  ? 2'd2 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act  <= '0;
      div_pend <= '0;
      pend_v   <= 1'b0;
    end else if (!en) begin
      if (div_we)      div_act <= div_wdata;
      else if (pend_v) div_act <= div_pend;
      pend_v <= 1'b0;
    end else if (wrap) begin
      if (div_we)      div_act <= div_wdata;
      else if (pend_v) div_act <= div_pend;
      pend_v <= 1'b0;
    end else if (div_we) begin
      div_pend <= div_wdata;
      pend_v   <= 1'b1;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= per_last);

  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(div_act));

  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt == '0 && !scl_req && tick));

  a_r2_scl_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && scl_req != $past(scl_req)) |-> (cnt == '0 || cnt == half));

  a_r6_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && div_we) |=> div_act == $past(div_wdata));

endmodule

// File: tb/sim_scl_tap_divider.sv
module sim_scl_tap_divider;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, div_we = 1'b0;
  logic [5:0] div_wdata = '0;
  logic       scl_req, tick;
  logic [1:0] phase;

  int n_tests = 0, n_fail = 0, n_done = 0;
  bit finished = 0;
  int exp_q[$];

  scl_tap_divider u0 (.clk(clk), .rst_n(rst_n), .en(en), .div_we(div_we),
    .div_wdata(div_wdata), .scl_req(scl_req), .tick(tick), .phase(phase));

  always #4 clk = ~clk;

  function automatic int model_half(input logic [5:0] v);
    int taps[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    int firsts[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    int t = taps[{v[5], v[1:0]}];
    int s = v[4:2];
    return firsts[s] + (t - 1) * (1 << s) + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: measures each complete period and compares with the queue
  bit in_per = 0;
  int cyc, low_c, high_c, ntk;
  int tk[3];
  int ph[3];
  always @(negedge clk) begin
    if (!en) begin
      in_per = 0;
    end else begin
      if (tick && phase == 2'd0) begin
        if (in_per) begin
          int h, q;
          if (exp_q.size() == 0) begin
            check(0, "R5 unexpected period", 2 * low_c, 0);
          end else begin
            h = exp_q.pop_front();
            q = h / 2;
            check(low_c == h && high_c == h, "R1/R2 low+high period", low_c + high_c, 2 * h);
            check(low_c == h, "R2 low half", low_c, h);
            check(ntk == 3 && tk[0] == q && tk[1] == h && tk[2] == h + q, "R3 tick offsets",
                  tk[0] * 10000 + tk[1] * 100 + tk[2], q * 10000 + h * 100 + h + q);
            check(ph[0] == 1 && ph[1] == 2 && ph[2] == 3, "R3 phases",
                  ph[0] * 100 + ph[1] * 10 + ph[2], 123);
          end
          n_done++;
        end
        in_per = 1; cyc = 0; low_c = 0; high_c = 0; ntk = 0;
      end
      if (in_per) begin
        if (scl_req) high_c++; else low_c++;
        if (tick && cyc != 0) begin
          if (ntk < 3) begin tk[ntk] = cyc; ph[ntk] = int'(phase); end
          ntk++;
        end
        cyc++;
      end
    end
  end

  task automatic drive_cycle();
    @(posedge clk); #2;
  endtask

  task automatic write_div(input logic [5:0] v);
    div_wdata = v; div_we = 1'b1;
    drive_cycle();
    div_we = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) drive_cycle();
  endtask

  task automatic run_idle_cfg(input logic [5:0] v, input int nper);
    en = 1'b0; drive_cycle();
    write_div(v);
    for (int i = 0; i < nper; i++) exp_q.push_back(model_half(v));
    n_done = 0;
    en = 1'b1;
    wait_done(nper);
    en = 1'b0; drive_cycle();
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) drive_cycle();
    // R8: reset state
    check(scl_req == 1'b1 && tick == 1'b0, "R8 reset SCL released", scl_req, 1);
    rst_n = 1'b1; drive_cycle();
    // R4 + R8: disabled outputs, then default divider period 28
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(scl_req && !tick && phase == 2'd0, "R4 disabled outputs", {scl_req, tick, phase}, 8);
      drive_cycle();
    end
    exp_q.push_back(model_half(6'h00));
    exp_q.push_back(model_half(6'h00));
    check(model_half(6'h00) == 14, "R8 default half", model_half(6'h00), 14);
    n_done = 0; en = 1'b1;
    @(negedge clk);
    check(tick && !scl_req && phase == 2'd0, "R4 start low with tick", {tick, scl_req}, 2);
    wait_done(2);
    en = 1'b0; drive_cycle();
    @(negedge clk);
    check(scl_req && !tick, "R4 released after disable", scl_req, 1);

    // R6 / R1: idle writes with assorted values
    run_idle_cfg(6'h01, 2);   // tap 10, scale 0 -> odd half 15
    run_idle_cfg(6'h26, 2);   // tap 5+? index 6 -> 7, scale 1
    run_idle_cfg(6'h0B, 2);   // tap 15, scale 2
    run_idle_cfg(6'h31, 1);   // tap 6, scale 4
    // R7: extremes
    run_idle_cfg(6'h20, 3);
    check(model_half(6'h20) * 2 == 20, "R7 min period", model_half(6'h20) * 2, 20);
    run_idle_cfg(6'h1F, 2);
    check(model_half(6'h1F) * 2 == 3840, "R7 max period", model_half(6'h1F) * 2, 3840);

    // R5: write while enabled applies at next boundary
    en = 1'b0; drive_cycle();
    write_div(6'h02);
    exp_q.push_back(model_half(6'h02));
    exp_q.push_back(model_half(6'h02));
    exp_q.push_back(model_half(6'h15));
    exp_q.push_back(model_half(6'h15));
    n_done = 0; en = 1'b1;
    wait_done(1);
    repeat (5) drive_cycle();
    write_div(6'h15);
    wait_done(4);
    en = 1'b0; drive_cycle();
    check(exp_q.size() == 0, "R5 all periods seen", exp_q.size(), 0);

    finish_run();
  end
endmodule